// File: doc/BRIEF.md
# Receive Destination Address Filter

This block sits on the receive path of an Ethernet MAC and decides, once per frame, whether the frame is kept or dropped. Frame bytes arrive one per valid beat, with start and end markers and a good-frame flag that is sampled on the final beat. The first six bytes of every frame are the destination address. They are compared one octet at a time, as they arrive, against a station address and against the all-ones broadcast address. No address bytes are stored.

The station address is supplied on three 16-bit words. Word 2 carries the first octet on the wire, word 0 carries the last two, and the lower-numbered octet of each pair sits in the low byte. Four enable inputs select the acceptance rules: broadcast, exact station match, accept-any-address, and pass-short-frames. One cycle after the final beat, the block raises a single-cycle decision strobe together with the accept bit. It also updates a byte count of the frame, and that count holds until the next decision.

Top module: `rx_daddr_filter`

## Requirements
- R1: While reset is held and after its release, `dec_valid`, `dec_accept` and `frame_len` are 0 until a frame completes.
- R2: `dec_valid` is high for exactly the one cycle after the clock edge that samples a frame's end beat (`rx_valid` and `rx_eof` high inside a frame), and at no other time. `dec_accept` is never high without `dec_valid`.
- R3: Octet k of the destination is the k-th byte of the frame. The station address maps octet 0 to `stn_word2[7:0]`, octet 1 to `stn_word2[15:8]`, octets 2/3 to `stn_word1` (low byte, high byte) and octets 4/5 to `stn_word0` (low byte, high byte). With `keep_match` high, a frame whose six destination octets all equal the station octets is accepted.
- R4: With `keep_bcast` high, a frame whose destination is six 0xFF octets is accepted. A destination that differs from the station address in any single octet (first or last) does not count as a match.
- R5: A frame that satisfies no enabled rule is dropped, including a station-matching frame when `keep_match` is low and a broadcast frame when `keep_bcast` is low.
- R6: With `keep_all` high, a frame is accepted whatever its destination address.
- R7: A frame of fewer than MIN_LEN bytes is dropped unless `keep_short` is high. A frame of exactly MIN_LEN bytes is not short.
- R8: A frame whose `rx_good` is low on its end beat is dropped, even if its address matches or `keep_all` is high.
- R9: `frame_len` becomes the number of valid beats from the start beat to the end beat inclusive, saturating at 2^LEN_W-1, and changes only together with `dec_valid`.
- R10: Beats with `rx_valid` low are ignored whatever their markers. Valid beats outside a frame (no start marker seen) are ignored and give no decision.
- R11: A start beat inside an unfinished frame abandons that frame and starts a new one. Only the new frame gets a decision.
- R12: A frame shorter than six bytes never satisfies the match or broadcast rule, so it can be accepted only through `keep_all`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Byte beat valid |
| rx_sof | input | 1 | First byte of a frame |
| rx_eof | input | 1 | Last byte of a frame |
| rx_data | input | 8 | Frame byte |
| rx_good | input | 1 | Frame free of errors, sampled on the end beat |
| stn_word0 | input | 16 | Station octets 4 (low byte) and 5 (high byte) |
| stn_word1 | input | 16 | Station octets 2 (low byte) and 3 (high byte) |
| stn_word2 | input | 16 | Station octets 0 (low byte) and 1 (high byte) |
| keep_bcast | input | 1 | Accept the all-ones destination |
| keep_match | input | 1 | Accept an exact station-address destination |
| keep_all | input | 1 | Accept any destination |
| keep_short | input | 1 | Do not drop frames shorter than MIN_LEN |
| dec_valid | output | 1 | One-cycle decision strobe |
| dec_accept | output | 1 | Frame accepted (meaningful with dec_valid) |
| frame_len | output | LEN_W | Byte count of the last decided frame |

## Verification
The bench builds the filter with MIN_LEN = 64 and LEN_W = 7. With those values, a 130-byte frame drives the length counter past 127, so saturation is exercised with short simulations. Frames of 63 and 64 bytes fall on either side of the short-frame limit. Since 2^LEN_W-1 = 127 sits above MIN_LEN, a saturated count is still a full-size frame, so the runt boundary and the saturation point can be checked separately.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
    localparam int OCTETS = 6;
    localparam int IDX_W  = $clog2(OCTETS + 1);

    typedef logic [IDX_W-1:0] oct_idx_t;

    // running destination-address comparison state
    typedef struct packed {
        oct_idx_t idx;
        logic     hit;
        logic     bcast;
    } cmp_st_t;
endpackage

// File: rtl/rxf_addr_cmp.sv
module rxf_addr_cmp
    import rxf_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  take,
    input  logic                  first,
    input  logic [7:0]            data,
    input  logic [OCTETS*8-1:0]   stn_flat,
    output logic                  hit_now,
    output logic                  bcast_now,
    output logic                  full_now
);
    cmp_st_t st_q, st_d, base, upd;
    logic [7:0] cur_oct;

    always_comb begin
        base = first ? '{idx: '0, hit: 1'b1, bcast: 1'b1} : st_q;
        cur_oct = '0;
        for (int k = 0; k < OCTETS; k++) begin
            if (base.idx == oct_idx_t'(k)) cur_oct = stn_flat[8*k +: 8];
        end
        upd = base;
        if (base.idx < oct_idx_t'(OCTETS)) begin
            upd.hit   = base.hit & (data == cur_oct);
            upd.bcast = base.bcast & (data == 8'hFF);
            upd.idx   = base.idx + oct_idx_t'(1);
        end
        st_d      = take ? upd : st_q;
        hit_now   = upd.hit;
        bcast_now = upd.bcast;
        full_now  = (upd.idx == oct_idx_t'(OCTETS));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{idx: '0, hit: 1'b0, bcast: 1'b0};
        else        st_q <= st_d;
    end
endmodule

// File: rtl/rxf_len_ctr.sv
module rxf_len_ctr #(
    parameter int LEN_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vld,
    input  logic             sof,
    input  logic             eof,
    output logic             take,
    output logic             first,
    output logic             last,
    output logic [LEN_W-1:0] len_now
);
    localparam logic [LEN_W-1:0] LEN_MAX = {LEN_W{1'b1}};

    typedef struct packed {
        logic             busy;
        logic [LEN_W-1:0] cnt;
    } len_st_t;

    len_st_t st_q, st_d;
    logic [LEN_W-1:0] base;

    always_comb begin
        take    = vld && (sof || st_q.busy);
        first   = vld && sof;
        last    = take && eof;
        base    = sof ? '0 : st_q.cnt;
        len_now = (base == LEN_MAX) ? base : base + 1'b1;
        st_d    = st_q;
        if (take) begin
            st_d.busy = !eof;
            st_d.cnt  = len_now;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{busy: 1'b0, cnt: '0};
        else        st_q <= st_d;
    end
endmodule

// File: rtl/rx_daddr_filter.sv
module rx_daddr_filter
    import rxf_pkg::*;
#(
    parameter int MIN_LEN = 64,
    parameter int LEN_W   = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_valid,
    input  logic             rx_sof,
    input  logic             rx_eof,
    input  logic [7:0]       rx_data,
    input  logic             rx_good,
    input  logic [15:0]      stn_word0,
    input  logic [15:0]      stn_word1,
    input  logic [15:0]      stn_word2,
    input  logic             keep_bcast,
    input  logic             keep_match,
    input  logic             keep_all,
    input  logic             keep_short,
    output logic             dec_valid,
    output logic             dec_accept,
    output logic [LEN_W-1:0] frame_len
);
    localparam int WORDS = OCTETS / 2;

    typedef struct packed {
        logic             vld;
        logic             acc;
        logic [LEN_W-1:0] len;
    } dec_st_t;

    logic [15:0]           words [WORDS];
    logic [OCTETS*8-1:0]   stn_flat;
    logic                  take, first, last;
    logic [LEN_W-1:0]      len_now;
    logic                  hit_now, bcast_now, full_now;
    logic                  size_ok, addr_ok;
    dec_st_t               dec_q, dec_d;

    assign words[0] = stn_word0;
    assign words[1] = stn_word1;
    assign words[2] = stn_word2;

    // the highest-numbered word carries the first octets on the wire
    for (genvar gi = 0; gi < WORDS; gi++) begin : g_oct
        assign stn_flat[16*gi +: 8]     = words[WORDS-1-gi][7:0];
        assign stn_flat[16*gi + 8 +: 8] = words[WORDS-1-gi][15:8];
    end

    rxf_len_ctr #(.LEN_W(LEN_W)) u_len (
        .clk     (clk),
        .rst_n   (rst_n),
        .vld     (rx_valid),
        .sof     (rx_sof),
        .eof     (rx_eof),
        .take    (take),
        .first   (first),
        .last    (last),
        .len_now (len_now)
    );

    rxf_addr_cmp u_cmp (
        .clk       (clk),
        .rst_n     (rst_n),
        .take      (take),
        .first     (first),
        .data      (rx_data),
        .stn_flat  (stn_flat),
        .hit_now   (hit_now),
        .bcast_now (bcast_now),
        .full_now  (full_now)
    );

    always_comb begin
        size_ok = keep_short || (len_now >= LEN_W'(MIN_LEN));
        addr_ok = keep_all
               || (keep_bcast && bcast_now && full_now)
               || (keep_match && hit_now && full_now);
        dec_d     = dec_q;
        dec_d.vld = last;
        dec_d.acc = last && rx_good && size_ok && addr_ok;
        if (last) dec_d.len = len_now;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) dec_q <= '{vld: 1'b0, acc: 1'b0, len: '0};
        else        dec_q <= dec_d;
    end

    assign dec_valid  = dec_q.vld;
    assign dec_accept = dec_q.acc;
    assign frame_len  = dec_q.len;
endmodule

// File: rtl/rxf_filter_chk.sv
module rxf_filter_chk #(
    parameter int MIN_LEN = 64,
    parameter int LEN_W   = 11
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rx_valid,
    input logic             rx_eof,
    input logic             rx_good,
    input logic             keep_bcast,
    input logic             keep_match,
    input logic             keep_all,
    input logic             keep_short,
    input logic             dec_valid,
    input logic             dec_accept,
    input logic [LEN_W-1:0] frame_len
);
    // R2
    strobe_after_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |-> $past(rx_valid && rx_eof));

    // R2
    accept_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_valid |-> !dec_accept);

    // R8
    bad_frame_dropped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec_accept |-> $past(rx_good));

    // R7
    short_frame_dropped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_accept && !$past(keep_short)) |-> (frame_len >= LEN_W'(MIN_LEN)));

    // R5
    needs_enabled_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec_accept |-> $past(keep_all || keep_bcast || keep_match));

    // R9
    len_moves_with_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(frame_len) |-> dec_valid);
endmodule

bind rx_daddr_filter rxf_filter_chk #(.MIN_LEN(MIN_LEN), .LEN_W(LEN_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_valid   (rx_valid),
    .rx_eof     (rx_eof),
    .rx_good    (rx_good),
    .keep_bcast (keep_bcast),
    .keep_match (keep_match),
    .keep_all   (keep_all),
    .keep_short (keep_short),
    .dec_valid  (dec_valid),
    .dec_accept (dec_accept),
    .frame_len  (frame_len)
);

// File: tb/rx_daddr_filter_test.sv
module rx_daddr_filter_test;
    localparam int MIN_LEN = 64;
    localparam int LEN_W   = 7;
    localparam int LMAX    = (1 << LEN_W) - 1;
    localparam logic [47:0] STN   = 48'h021A3C5E709B;
    localparam logic [47:0] BCAST = 48'hFFFFFFFFFFFF;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_valid = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0, rx_good = 1'b0;
    logic [7:0] rx_data = '0;
    logic keep_bcast = 1'b0, keep_match = 1'b0, keep_all = 1'b0, keep_short = 1'b0;
    logic dec_valid, dec_accept;
    logic [LEN_W-1:0] frame_len;
    logic [15:0] w0, w1, w2;

    typedef struct {
        bit    acc;
        int    len;
        string tag;
    } exp_t;

    exp_t sb[$];
    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    // octet 0 = STN[47:40] goes in the low byte of word 2
    assign w2 = {STN[39:32], STN[47:40]};
    assign w1 = {STN[23:16], STN[31:24]};
    assign w0 = {STN[7:0],   STN[15:8]};

    rx_daddr_filter #(.MIN_LEN(MIN_LEN), .LEN_W(LEN_W)) uut (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_sof(rx_sof),
        .rx_eof(rx_eof), .rx_data(rx_data), .rx_good(rx_good),
        .stn_word0(w0), .stn_word1(w1), .stn_word2(w2),
        .keep_bcast(keep_bcast), .keep_match(keep_match),
        .keep_all(keep_all), .keep_short(keep_short),
        .dec_valid(dec_valid), .dec_accept(dec_accept), .frame_len(frame_len)
    );

    function automatic bit model(logic [47:0] dst, int n, bit good);
        bit full  = (n >= 6);
        bit sz    = keep_short || (n >= MIN_LEN);
        bit rule  = keep_all
                 || (keep_bcast && full && dst == BCAST)
                 || (keep_match && full && dst == STN);
        return good && sz && rule;
    endfunction

    // scoreboard monitor
    always @(negedge clk) begin
        exp_t e;
        if (rst_n && dec_valid && !done) begin
            checks++;
            if (sb.size() == 0) begin
                fails++;
                $display("FAIL R10 unexpected decision: actual acc=%0d len=%0d expected none",
                         dec_accept, frame_len);
            end else begin
                e = sb.pop_front();
                if (dec_accept !== e.acc || frame_len !== LEN_W'(e.len)) begin
                    fails++;
                    $display("FAIL %s: actual acc=%0d len=%0d expected acc=%0d len=%0d",
                             e.tag, dec_accept, frame_len, e.acc, e.len);
                end
            end
        end
    end

    task automatic beat(bit v, bit s, bit e, logic [7:0] d, bit g);
        @(negedge clk);
        rx_valid = v; rx_sof = s; rx_eof = e; rx_data = d; rx_good = g;
    endtask

    task automatic check_strobe(bit exp, string tag);
        checks++;
        if (dec_valid !== exp) begin
            fails++;
            $display("FAIL %s: actual dec_valid=%0d expected %0d", tag, dec_valid, exp);
        end
    endtask

    task automatic send_frame(logic [47:0] dst, int n, bit good, string tag);
        exp_t e;
        e.acc = model(dst, n, good);
        e.len = (n > LMAX) ? LMAX : n;
        e.tag = tag;
        sb.push_back(e);
        for (int i = 0; i < n; i++) begin
            // R10: idle beat with markers set, must be ignored
            if (i % 7 == 6) beat(1'b0, 1'b1, 1'b1, 8'hFF, 1'b0);
            beat(1'b1, i == 0, i == n - 1,
                 (i < 6) ? dst[47-8*i -: 8] : 8'(i * 3 + 1), good);
        end
        @(negedge clk);
        check_strobe(1'b1, "R2 strobe after end beat");
        rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0;
        @(negedge clk);
        check_strobe(1'b0, "R2 strobe one cycle only");
    endtask

    task automatic set_cfg(bit b, bit m, bit a, bit s);
        keep_bcast = b; keep_match = m; keep_all = a; keep_short = s;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected completion");
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (dec_valid !== 1'b0 || dec_accept !== 1'b0 || frame_len !== '0) begin
            fails++;
            $display("FAIL R1 in reset: actual %0d/%0d/%0d expected 0/0/0",
                     dec_valid, dec_accept, frame_len);
        end
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        checks++;
        if (dec_valid !== 1'b0 || dec_accept !== 1'b0 || frame_len !== '0) begin
            fails++;
            $display("FAIL R1 after reset: actual %0d/%0d/%0d expected 0/0/0",
                     dec_valid, dec_accept, frame_len);
        end

        set_cfg(0, 1, 0, 0);
        send_frame(STN, 80, 1, "R3 exact station match");
        send_frame(STN ^ 48'h1, 80, 1, "R4 last octet differs");
        send_frame(STN ^ 48'h800000000000, 80, 1, "R4 first octet differs");
        send_frame(BCAST, 70, 1, "R5 broadcast with rule off");
        set_cfg(1, 0, 0, 0);
        send_frame(BCAST, 70, 1, "R4 broadcast accepted");
        send_frame(STN, 70, 1, "R5 station with match rule off");
        set_cfg(0, 0, 0, 0);
        send_frame(STN, 70, 1, "R5 no rule enabled");
        set_cfg(0, 0, 1, 0);
        send_frame(48'h123456789ABC, 66, 1, "R6 pass all any address");
        send_frame(48'h123456789ABC, 66, 0, "R8 pass all bad frame");
        set_cfg(0, 1, 0, 0);
        send_frame(STN, 63, 1, "R7 63 bytes dropped");
        send_frame(STN, 64, 1, "R7 64 bytes kept");
        send_frame(STN, 80, 0, "R8 bad station frame");
        set_cfg(0, 1, 0, 1);
        send_frame(STN, 63, 1, "R7 short kept with keep_short");
        send_frame(STN, 4, 1, "R12 truncated address no match");
        set_cfg(1, 0, 0, 1);
        send_frame(BCAST, 5, 1, "R12 truncated broadcast no match");
        set_cfg(0, 0, 1, 1);
        send_frame(STN, 4, 1, "R12 truncated via pass all");
        set_cfg(0, 1, 0, 0);
        send_frame(STN, 130, 1, "R9 length saturates");
        send_frame(STN, 65, 1, "R9 length after saturation");

        // R10: valid beats with no start marker
        for (int i = 0; i < 5; i++) beat(1'b1, 1'b0, i == 4, 8'h02, 1'b1);
        beat(1'b0, 1'b0, 1'b0, 8'h00, 1'b0);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check_strobe(1'b0, "R10 stray beats no decision");
        end
        checks++;
        if (frame_len !== LEN_W'(65)) begin
            fails++;
            $display("FAIL R9 length held: actual %0d expected 65", frame_len);
        end

        // R11: abandoned frame then restart
        for (int i = 0; i < 3; i++) beat(1'b1, i == 0, 1'b0, 8'hFF, 1'b1);
        send_frame(STN, 72, 1, "R11 restarted frame");

        repeat (5) @(negedge clk);
        checks++;
        if (sb.size() != 0) begin
            fails++;
            $display("FAIL R2 missing decisions: actual %0d pending expected 0", sb.size());
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule